// File: doc/BRIEF.md
# Dual-Master Channel Access Arbiter

This block decides which of two masters may drive a shared auxiliary channel engine: the software register path or an embedded microcontroller. A two-bit ownership field reports the current holder at all times. The microcontroller claims the channel by holding a request level and gives it back with a release pulse. Software starts an acquire attempt with a one-cycle request pulse and gives the channel back with a done pulse. Every acquire attempt ends with a one-cycle completion pulse and a success flag.

An acquire attempt is refused at once if the microcontroller holds the channel. If the engine has never been switched on, the block first runs a bring-up handshake. It turns the engine on and puts it into reset in the same cycle. It waits for the engine to report reset-done, releases reset, and then waits for reset-done to clear. Each of these waits checks the engine once per poll interval and gives up after a fixed number of polls. When a wait gives up, the sequence carries on anyway.

After any bring-up, the block raises an internal software use-request toward the ownership logic. The attempt succeeds only if the ownership field then reads software. Once granted, ownership stays with its holder until that holder releases it. There is no preemption.

Top module: `chan_access_arbiter`

## Requirements
- R1: `owner_o` encodes 0 as idle, 1 as software-owned and 2 as microcontroller-owned, and never shows 3. After reset, `owner_o` is 0 and `eng_en_o`, `eng_rst_o` and `acq_done_o` are all low.
- R2: A software request seen while `owner_o` is 2 ends with `acq_done_o` high and `acq_ok_o` low in the very next cycle. Such a refused request starts no bring-up activity.
- R3: If the engine is disabled when a software request is accepted, `eng_en_o` and `eng_rst_o` rise in the same cycle.
- R4: `eng_rst_o` stays high until `eng_rst_done_i` is sampled high at a poll, and then falls. The use-request is not raised until `eng_rst_done_i` has been sampled low again, or that wait has expired.
- R5: Each of the two waits takes at most `MAX_POLLS` polls, spaced `POLL_INTERVAL` cycles apart. When a wait expires, the sequence continues, so `eng_rst_o` is high for at most `MAX_POLLS*POLL_INTERVAL` consecutive cycles.
- R6: After bring-up, or at once when the engine is already enabled, the block raises the use-request. The completion pulse reports success exactly when `owner_o` reads 1. With the engine enabled and the channel free, the completion pulse appears three cycles after the request is sampled.
- R7: A software done pulse returns ownership from 1 to 0 in the next cycle. The pulse has no effect while software is not the owner.
- R8: If the microcontroller request and the software use-request both reach an idle channel in the same cycle, the microcontroller wins, and the software attempt reports failure.
- R9: Ownership is held until the owning master releases it. A request or release from the other master while the channel is owned leaves `owner_o` unchanged.
- R10: Once set, `eng_en_o` stays high until reset. A later acquire attempt does not repeat the reset handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req_i | input | 1 | Software acquire request pulse |
| sw_done_i | input | 1 | Software release pulse |
| mcu_req_i | input | 1 | Microcontroller request level |
| mcu_done_i | input | 1 | Microcontroller release pulse |
| eng_rst_done_i | input | 1 | Reset-done indication from the engine |
| owner_o | output | 2 | Ownership status (0 idle, 1 software, 2 microcontroller) |
| eng_en_o | output | 1 | Engine enable |
| eng_rst_o | output | 1 | Engine reset |
| acq_done_o | output | 1 | One-cycle pulse that ends an acquire attempt |
| acq_ok_o | output | 1 | Success flag, valid with `acq_done_o` |

## Verification
The bench aims at three orderings.

The first is a software request that meets the microcontroller in the same cycle. A design with the priority reversed would grant software.

The second is a refusal while the microcontroller owns the channel. A design that let the request through would disturb the engine or break its latency of one cycle.

The third covers the bring-up waits with the engine's reset-done stuck low and stuck high. A design without the poll limits would hang, and a design that skipped the second wait would request the channel while reset-done was still high.

A second acquire must leave the engine reset untouched, and release pulses from the master that does not own the channel must be ignored.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;

    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_SW   = 2'd1,
        OWN_MCU  = 2'd2
    } owner_e;

    typedef enum logic [1:0] {
        ACQ_IDLE,
        ACQ_ENABLE,
        ACQ_REQ,
        ACQ_CHECK
    } acq_state_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAIT_HI,
        SEQ_WAIT_LO
    } seq_state_e;

    typedef struct packed {
        logic done;
        logic ok;
    } acq_result_t;

    function automatic logic sw_blocked(owner_e own);
        return own == OWN_MCU;
    endfunction

endpackage

// File: rtl/chan_owner_arb.sv
module chan_owner_arb
    import chan_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sw_use_req,
    input  logic   sw_release,
    input  logic   mcu_req,
    input  logic   mcu_release,
    output owner_e owner
);

    owner_e owner_q, owner_d;

    always_comb begin
        owner_d = owner_q;
        case (owner_q)
            OWN_IDLE: begin
                if (mcu_req)         owner_d = OWN_MCU;
                else if (sw_use_req) owner_d = OWN_SW;
            end
            OWN_SW:  if (sw_release)  owner_d = OWN_IDLE;
            OWN_MCU: if (mcu_release) owner_d = OWN_IDLE;
            default: owner_d = OWN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= OWN_IDLE;
        else     owner_q <= owner_d;
    end

    assign owner = owner_q;

endmodule

// File: rtl/chan_enable_seq.sv
module chan_enable_seq
    import chan_arb_pkg::*;
#(
    parameter int POLL_INTERVAL = 1,
    parameter int MAX_POLLS     = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rst_done,
    output logic eng_en,
    output logic eng_rst,
    output logic done
);

    localparam int TW = (POLL_INTERVAL > 1) ? $clog2(POLL_INTERVAL) : 1;
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(POLL_INTERVAL - 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

    seq_state_e    state_q;
    logic [TW-1:0] tick_q;
    logic [PW-1:0] polls_q;
    logic          en_q, rst_q, done_q;
    logic          poll_now, poll_final;

    assign poll_now   = (tick_q == TICK_LAST);
    assign poll_final = (polls_q == POLL_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            tick_q  <= '0;
            polls_q <= '0;
            en_q    <= 1'b0;
            rst_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        en_q    <= 1'b1;
                        rst_q   <= 1'b1;
                        tick_q  <= '0;
                        polls_q <= '0;
                        state_q <= SEQ_WAIT_HI;
                    end
                end
                SEQ_WAIT_HI: begin
                    if (poll_now) begin
                        tick_q <= '0;
                        if (rst_done || poll_final) begin
                            rst_q   <= 1'b0;
                            polls_q <= '0;
                            state_q <= SEQ_WAIT_LO;
                        end else begin
                            polls_q <= polls_q + 1'b1;
                        end
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                SEQ_WAIT_LO: begin
                    if (poll_now) begin
                        tick_q <= '0;
                        if (!rst_done || poll_final) begin
                            done_q  <= 1'b1;
                            state_q <= SEQ_IDLE;
                        end else begin
                            polls_q <= polls_q + 1'b1;
                        end
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign eng_en  = en_q;
    assign eng_rst = rst_q;
    assign done    = done_q;

endmodule

// File: rtl/chan_acquire_fsm.sv
module chan_acquire_fsm
    import chan_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_req,
    input  owner_e      owner,
    input  logic        eng_en,
    input  logic        seq_done,
    output logic        seq_start,
    output logic        use_req,
    output acq_result_t result
);

    acq_state_e  state_q;
    acq_result_t res_q;
    logic        accept;

    assign accept    = (state_q == ACQ_IDLE) && sw_req && !sw_blocked(owner);
    assign seq_start = accept && !eng_en;
    assign use_req   = (state_q == ACQ_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACQ_IDLE;
            res_q   <= '0;
        end else begin
            res_q <= '0;
            case (state_q)
                ACQ_IDLE: begin
                    if (sw_req && sw_blocked(owner)) begin
                        res_q.done <= 1'b1;
                        res_q.ok   <= 1'b0;
                    end else if (accept) begin
                        state_q <= eng_en ? ACQ_REQ : ACQ_ENABLE;
                    end
                end
                ACQ_ENABLE: if (seq_done) state_q <= ACQ_REQ;
                ACQ_REQ:    state_q <= ACQ_CHECK;
                ACQ_CHECK: begin
                    res_q.done <= 1'b1;
                    res_q.ok   <= (owner == OWN_SW);
                    state_q    <= ACQ_IDLE;
                end
                default: state_q <= ACQ_IDLE;
            endcase
        end
    end

    assign result = res_q;

endmodule

// File: rtl/chan_access_arbiter.sv
module chan_access_arbiter
    import chan_arb_pkg::*;
#(
    parameter int POLL_INTERVAL = 1,
    parameter int MAX_POLLS     = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_req_i,
    input  logic       sw_done_i,
    input  logic       mcu_req_i,
    input  logic       mcu_done_i,
    input  logic       eng_rst_done_i,
    output logic [1:0] owner_o,
    output logic       eng_en_o,
    output logic       eng_rst_o,
    output logic       acq_done_o,
    output logic       acq_ok_o
);

    owner_e      owner;
    logic        use_req, seq_start, seq_done, eng_en, eng_rst;
    acq_result_t result;

    chan_owner_arb u_owner (
        .clk         (clk),
        .rst         (rst),
        .sw_use_req  (use_req),
        .sw_release  (sw_done_i),
        .mcu_req     (mcu_req_i),
        .mcu_release (mcu_done_i),
        .owner       (owner)
    );

    chan_enable_seq #(
        .POLL_INTERVAL (POLL_INTERVAL),
        .MAX_POLLS     (MAX_POLLS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (seq_start),
        .rst_done (eng_rst_done_i),
        .eng_en   (eng_en),
        .eng_rst  (eng_rst),
        .done     (seq_done)
    );

    chan_acquire_fsm u_acq (
        .clk       (clk),
        .rst       (rst),
        .sw_req    (sw_req_i),
        .owner     (owner),
        .eng_en    (eng_en),
        .seq_done  (seq_done),
        .seq_start (seq_start),
        .use_req   (use_req),
        .result    (result)
    );

    assign owner_o    = owner;
    assign eng_en_o   = eng_en;
    assign eng_rst_o  = eng_rst;
    assign acq_done_o = result.done;
    assign acq_ok_o   = result.ok;

endmodule

// File: rtl/chan_access_arbiter_chk.sv
module chan_access_arbiter_chk #(
    parameter int POLL_INTERVAL = 1,
    parameter int MAX_POLLS     = 11
) (
    input logic       clk,
    input logic       rst,
    input logic       sw_done_i,
    input logic       mcu_req_i,
    input logic       mcu_done_i,
    input logic [1:0] owner_o,
    input logic       eng_en_o,
    input logic       eng_rst_o,
    input logic       acq_done_o,
    input logic       acq_ok_o
);

    localparam int unsigned RST_LIMIT = POLL_INTERVAL * MAX_POLLS;

    int unsigned rst_run_q;

    always_ff @(posedge clk) begin
        if (rst)            rst_run_q <= 0;
        else if (eng_rst_o) rst_run_q <= rst_run_q + 1;
        else                rst_run_q <= 0;
    end

    a_r1_owner_legal: assert property (@(posedge clk) disable iff (rst)
        owner_o != 2'd3);

    a_r3_rst_with_en: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_rst_o) |-> $rose(eng_en_o));

    a_r5_rst_window: assert property (@(posedge clk) disable iff (rst)
        eng_rst_o |-> (rst_run_q < RST_LIMIT));

    a_r6_ok_means_sw: assert property (@(posedge clk) disable iff (rst)
        (acq_done_o && acq_ok_o) |-> (owner_o == 2'd1));

    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (owner_o == 2'd1 && sw_done_i) |=> (owner_o == 2'd0));

    a_r8_mcu_wins: assert property (@(posedge clk) disable iff (rst)
        (owner_o == 2'd0 && mcu_req_i) |=> (owner_o == 2'd2));

    a_r9_sw_hold: assert property (@(posedge clk) disable iff (rst)
        (owner_o == 2'd1 && !sw_done_i) |=> (owner_o == 2'd1));

    a_r9_mcu_hold: assert property (@(posedge clk) disable iff (rst)
        (owner_o == 2'd2 && !mcu_done_i) |=> (owner_o == 2'd2));

    a_r10_en_sticky: assert property (@(posedge clk) disable iff (rst)
        eng_en_o |=> eng_en_o);

endmodule

bind chan_access_arbiter chan_access_arbiter_chk #(
    .POLL_INTERVAL (POLL_INTERVAL),
    .MAX_POLLS     (MAX_POLLS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_done_i  (sw_done_i),
    .mcu_req_i  (mcu_req_i),
    .mcu_done_i (mcu_done_i),
    .owner_o    (owner_o),
    .eng_en_o   (eng_en_o),
    .eng_rst_o  (eng_rst_o),
    .acq_done_o (acq_done_o),
    .acq_ok_o   (acq_ok_o)
);

// File: tb/sim_chan_access_arbiter.sv
`timescale 1ns/1ps
module sim_chan_access_arbiter;

    typedef struct {
        bit       ok;
        bit [1:0] owner;
        int       lat;
        string    tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_req_i = 1'b0, sw_done_i = 1'b0;
    logic       mcu_req_i = 1'b0, mcu_done_i = 1'b0;
    logic       eng_rst_done_i = 1'b0;
    logic [1:0] owner_o;
    logic       eng_en_o, eng_rst_o, acq_done_o, acq_ok_o;

    int   n_checks = 0, n_fail = 0;
    int   cyc = 0, req_cyc = 0;
    int   rst_hi = 0, rst_rises = 0, rise_without_en = 0;
    logic rst_prev = 1'b0, en_prev = 1'b0;
    int   eng_mode = 0;
    logic [2:0] dly = '0;
    bit   finished = 1'b0;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    chan_access_arbiter u0 (
        .clk            (clk),
        .rst            (rst),
        .sw_req_i       (sw_req_i),
        .sw_done_i      (sw_done_i),
        .mcu_req_i      (mcu_req_i),
        .mcu_done_i     (mcu_done_i),
        .eng_rst_done_i (eng_rst_done_i),
        .owner_o        (owner_o),
        .eng_en_o       (eng_en_o),
        .eng_rst_o      (eng_rst_o),
        .acq_done_o     (acq_done_o),
        .acq_ok_o       (acq_ok_o)
    );

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        n_checks++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Engine model: mode 0 follows reset with a delay, 1 stuck low, 2 stuck high.
    always @(negedge clk) begin
        dly <= {dly[1:0], eng_rst_o};
        eng_rst_done_i <= (eng_mode == 1) ? 1'b0 : (eng_mode == 2) ? 1'b1 : dly[2];
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        if (rst) begin
            rst_hi = 0; rst_rises = 0; rise_without_en = 0;
        end else begin
            if (sw_req_i) req_cyc = cyc;
            if (eng_rst_o) rst_hi++;
            if (eng_rst_o && !rst_prev) begin
                rst_rises++;
                if (!(eng_en_o && !en_prev)) rise_without_en++;
            end
            if (acq_done_o) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R6 unexpected completion", 1, 0);
                end else begin
                    e = expq.pop_front();
                    chk(acq_ok_o == e.ok, {e.tag, " ok flag"}, acq_ok_o, e.ok);
                    chk(owner_o == e.owner, {e.tag, " owner"}, owner_o, e.owner);
                    if (e.lat >= 0)
                        chk(cyc - req_cyc == e.lat, {e.tag, " latency"}, cyc - req_cyc, e.lat);
                end
            end
        end
        rst_prev = eng_rst_o;
        en_prev  = eng_en_o;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input int mode);
        eng_mode = mode;
        rst = 1'b1;
        step(4);
        rst = 1'b0;
        step(1);
    endtask

    task automatic acquire(input bit ok, input bit [1:0] own, input int lat, input string tag,
                           input bit race_mcu);
        exp_t e;
        e.ok = ok; e.owner = own; e.lat = lat; e.tag = tag;
        expq.push_back(e);
        sw_req_i = 1'b1;
        step(1);
        sw_req_i = 1'b0;
        if (race_mcu) begin
            mcu_req_i = 1'b1;
            step(1);
            mcu_req_i = 1'b0;
        end
        while (expq.size() != 0) step(1);
        step(1);
    endtask

    task automatic pulse_sw_done();
        sw_done_i = 1'b1; step(1); sw_done_i = 1'b0;
    endtask

    task automatic pulse_mcu_done();
        mcu_done_i = 1'b1; step(1); mcu_done_i = 1'b0;
    endtask

    initial begin
        do_reset(0);
        // R1 reset state
        chk(owner_o == 2'd0, "R1 reset owner", owner_o, 0);
        chk(eng_en_o == 1'b0, "R1 reset enable", eng_en_o, 0);
        chk(eng_rst_o == 1'b0, "R1 reset engine reset", eng_rst_o, 0);
        chk(acq_done_o == 1'b0, "R1 reset completion", acq_done_o, 0);

        // R3/R4/R6 first acquire with bring-up
        acquire(1'b1, 2'd1, -1, "R6 first acquire", 1'b0);
        chk(rst_rises == 1, "R3 reset pulses", rst_rises, 1);
        chk(rise_without_en == 0, "R3 enable with reset", rise_without_en, 0);
        chk(rst_hi == 4, "R4 reset held until done", rst_hi, 4);
        chk(eng_rst_done_i == 1'b0, "R4 done low before grant", eng_rst_done_i, 0);
        chk(eng_en_o == 1'b1, "R10 enable set", eng_en_o, 1);

        // R6/R10 re-acquire while enabled and owned
        acquire(1'b1, 2'd1, 3, "R6 re-acquire", 1'b0);
        chk(rst_rises == 1, "R10 no second handshake", rst_rises, 1);

        // R9 microcontroller cannot preempt
        mcu_req_i = 1'b1; step(2); mcu_req_i = 1'b0;
        chk(owner_o == 2'd1, "R9 no preemption by mcu", owner_o, 1);

        // R7 release
        pulse_sw_done();
        chk(owner_o == 2'd0, "R7 release to idle", owner_o, 0);
        pulse_sw_done();
        chk(owner_o == 2'd0, "R7 done ignored when idle", owner_o, 0);

        // R9/R2 microcontroller ownership
        mcu_req_i = 1'b1; step(1); mcu_req_i = 1'b0;
        chk(owner_o == 2'd2, "R1 mcu owner code", owner_o, 2);
        pulse_sw_done();
        chk(owner_o == 2'd2, "R9 sw done ignored under mcu", owner_o, 2);
        acquire(1'b0, 2'd2, 1, "R2 refused under mcu", 1'b0);
        chk(rst_rises == 1, "R2 no engine activity", rst_rises, 1);
        pulse_mcu_done();
        chk(owner_o == 2'd0, "R9 mcu release", owner_o, 0);

        // R8 same-cycle contention
        acquire(1'b0, 2'd2, 3, "R8 mcu wins tie", 1'b0 | 1'b1);
        pulse_mcu_done();
        acquire(1'b1, 2'd1, 3, "R6 grant after tie", 1'b0);
        pulse_sw_done();
        chk(eng_en_o == 1'b1, "R10 enable still set", eng_en_o, 1);

        // R5 reset-done stuck low
        do_reset(1);
        acquire(1'b1, 2'd1, -1, "R5 stuck-low acquire", 1'b0);
        chk(rst_hi == 11, "R5 reset window on timeout", rst_hi, 11);

        // R5 reset-done stuck high
        do_reset(2);
        acquire(1'b1, 2'd1, -1, "R5 stuck-high acquire", 1'b0);
        chk(rst_hi == 1, "R5 early done drops reset", rst_hi, 1);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule